// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects sixteen interrupt channels, ranks them by a fixed priority and raises one request line towards a processor. Channels 0 to 7 are fed by an eight-pin general-purpose port. Each port pin is synchronized, can be set as an input or an output, and detects a chosen edge. Channels 8 to 15 are fed by single-cycle event pulses from neighbouring logic: `src_evt[k]` feeds channel 8+k. When the processor acknowledges a request, the block returns an 8-bit vector. The upper nibble of that vector comes from a programmable base and the lower nibble is the winning channel number.

Software controls the block through a byte-wide register port. Writes take effect at the clock edge. Reads are combinational and have no side effects. Each 16-bit channel register (enable, pending, mask, in-service) appears at two addresses: a high byte for channels 15..8 and a low byte for channels 7..0. Addresses not listed read as zero.

In the automatic end-of-interrupt mode the block can issue the next request right after an acknowledge. In the software mode each grant marks its channel as in service. Software must clear that mark before the block issues another request.

Top module: `vect_irq_ctrl`

## Requirements
- R1: Among channels whose mask bit and pending bit are both 1, the grant picks the highest-numbered one (15 highest, 0 lowest). A pending channel whose mask bit is 0 is never granted and stays pending. Mask is at address 0x9 (high byte) and 0xA (low byte).
- R2: While any in-service bit is 1, `irq_req` does not rise, even when a masked-in channel is pending.
- R3: An event sets a channel's pending bit only if that channel's enable bit is 1. Writing an enable byte (0x3 high, 0x4 low) also ANDs the pending register with the new enable value.
- R4: An acknowledge (`irq_ack` high in a cycle where `irq_req` is high) has these effects at that clock edge: `irq_req` drops, the granted channel's pending bit clears, and `irq_vec_vld` is high for exactly the next cycle with `irq_vec` = {vector byte bits 7:4, 4-bit channel}. The vector byte is at address 0xB.
- R5: Bit 3 of the vector byte selects software mode (1), where every grant sets the granted channel's in-service bit. Writing the vector byte with bit 3 = 0 clears all in-service bits. Only bits 7:3 are stored, and bits 2:0 read as 0.
- R6: Writing a pending byte (0x5 high, 0x6 low) ANDs it with the data, so a written 1 keeps a bit and never sets it. Writing an in-service byte (0x7 high, 0x8 low) loads it directly.
- R7: For each port pin with direction bit 0, the synchronized pin is XORed with its edge-select bit. A 1-to-0 change of that result is an event on channel equal to the pin index, so edge-select 1 means rising and 0 means falling. Pins with direction bit 1 produce no events. Edge-select is at address 0x1 and direction is at address 0x2.
- R8: A write to the port data byte (address 0x0) changes only the output latch bits whose direction bit is 1. `gpio_out` shows the latch and `gpio_oe` shows the direction. A read of 0x0 returns the synchronized inputs on input pins and the latch on output pins.
- R9: `irq_req` rises two clock edges after a source pulse is sampled, and then stays high until it is acknowledged.
- R10: After reset, all enable, pending, mask, in-service, direction, edge-select, output-latch and vector bits are 0, and `irq_req` and `irq_vec_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| src_evt | input | 8 | Event pulses for channels 15..8 |
| gpio_in | input | 8 | Port pin inputs (asynchronous) |
| gpio_out | output | 8 | Port output latch |
| gpio_oe | output | 8 | Port direction (1 = drive) |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_vec_vld | output | 1 | Vector valid, one cycle after an acknowledge |
| irq_vec | output | 8 | Interrupt vector |

## Verification
The checker assumes a few things about the block's inputs:
- The vector byte is not rewritten in the cycle of an acknowledge.
- The in-service byte is not written in the cycle of an acknowledge.
- No event for the just-granted channel arrives in the same cycle as its acknowledge.

Under these assumptions, each vector can be tied to the base and mode that were in force when it was granted. The directed stimulus respects them by spacing register writes, pulses and acknowledges into separate cycles, with several idle cycles between phases. Port pins are changed only at the falling clock edge, and the bench allows enough cycles for the two synchronizer stages before it looks at any pending bit.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned NCH   = 16;
  localparam int unsigned BYTE  = 8;
  localparam int unsigned CHW   = $clog2(NCH);
  localparam int unsigned NPORT = NCH - BYTE;

  typedef enum logic [3:0] {
    A_GPDAT = 4'h0,
    A_EDGE  = 4'h1,
    A_DIR   = 4'h2,
    A_ENA_H = 4'h3,
    A_ENA_L = 4'h4,
    A_PND_H = 4'h5,
    A_PND_L = 4'h6,
    A_SRV_H = 4'h7,
    A_SRV_L = 4'h8,
    A_MSK_H = 4'h9,
    A_MSK_L = 4'hA,
    A_VEC   = 4'hB
  } pic_addr_e;
endpackage

// File: rtl/pic_gpio_port.sv
module pic_gpio_port #(
  parameter int unsigned W     = 8,
  parameter int unsigned SYNC  = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         we_dat,
  input  logic         we_edge,
  input  logic         we_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] dat_rd,
  output logic [W-1:0] edge_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] evt
);
  logic [SYNC-1:0][W-1:0] sy_q, sy_n;
  logic [W-1:0] prev_q, prev_n;
  logic [W-1:0] edge_n, dir_n, out_n;
  logic [W-1:0] live, lvl_old, lvl_new;

  assign live = sy_q[SYNC-1];

  // synchronizer chain, next state
  always_comb begin
    sy_n[0] = pin_in;
    for (int k = 1; k < SYNC; k++) sy_n[k] = sy_q[k-1];
  end

  always_comb begin
    prev_n = live;
    edge_n = we_edge ? wdata : edge_q;
    dir_n  = we_dir  ? wdata : dir_q;
    out_n  = we_dat  ? ((wdata & dir_q) | (out_q & ~dir_q)) : out_q;
  end

  // both levels are judged with the present edge/direction setting so that
  // reprogramming them never fakes a transition
  assign lvl_old = (prev_q & ~dir_q) ^ edge_q;
  assign lvl_new = (live   & ~dir_q) ^ edge_q;
  assign evt     = lvl_old & ~lvl_new;
  assign dat_rd  = (live & ~dir_q) | (out_q & dir_q);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sy_q   <= '0;
      prev_q <= '0;
      edge_q <= '0;
      dir_q  <= '0;
      out_q  <= '0;
    end else begin
      sy_q   <= sy_n;
      prev_q <= prev_n;
      edge_q <= edge_n;
      dir_q  <= dir_n;
      out_q  <= out_n;
    end
  end
endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  output logic          any,
  output logic [IW-1:0] idx
);
  // ascending scan: the last set bit seen is the highest channel
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vect_irq_ctrl.sv
module vect_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic [7:0]  src_evt,
  input  logic [7:0]  gpio_in,
  output logic [7:0]  gpio_out,
  output logic [7:0]  gpio_oe,
  output logic        irq_req,
  input  logic        irq_ack,
  output logic        irq_vec_vld,
  output logic [7:0]  irq_vec
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsy_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsy_q <= '0;
    else        rsy_q <= {rsy_q[0], 1'b1};
  end
  assign rst_q_n = rsy_q[1];

  // write decode
  logic we_dat, we_edge, we_dir, we_ena_h, we_ena_l, we_pnd_h, we_pnd_l;
  logic we_srv_h, we_srv_l, we_msk_h, we_msk_l, we_vec;
  always_comb begin
    we_dat   = reg_we && (reg_addr == A_GPDAT);
    we_edge  = reg_we && (reg_addr == A_EDGE);
    we_dir   = reg_we && (reg_addr == A_DIR);
    we_ena_h = reg_we && (reg_addr == A_ENA_H);
    we_ena_l = reg_we && (reg_addr == A_ENA_L);
    we_pnd_h = reg_we && (reg_addr == A_PND_H);
    we_pnd_l = reg_we && (reg_addr == A_PND_L);
    we_srv_h = reg_we && (reg_addr == A_SRV_H);
    we_srv_l = reg_we && (reg_addr == A_SRV_L);
    we_msk_h = reg_we && (reg_addr == A_MSK_H);
    we_msk_l = reg_we && (reg_addr == A_MSK_L);
    we_vec   = reg_we && (reg_addr == A_VEC);
  end

  // port
  logic [BYTE-1:0] port_rd, edge_q, dir_q, out_q, port_evt;
  pic_gpio_port #(.W(BYTE), .SYNC(SYNC_STAGES)) u_port (
    .clk    (clk),
    .rst_ni (rst_q_n),
    .we_dat (we_dat),
    .we_edge(we_edge),
    .we_dir (we_dir),
    .wdata  (reg_wdata),
    .pin_in (gpio_in),
    .dat_rd (port_rd),
    .edge_q (edge_q),
    .dir_q  (dir_q),
    .out_q  (out_q),
    .evt    (port_evt)
  );
  assign gpio_out = out_q;
  assign gpio_oe  = dir_q;

  // channel state
  logic [NCH-1:0] ena_q, ena_n, pend_q, pend_n, msk_q, msk_n, isr_q, isr_n;
  logic [4:0]     vreg_q, vreg_n;
  logic           req_q, req_n, vld_q, vld_n;
  logic [CHW-1:0] ch_q, ch_n, cur_ch, pick_idx;
  logic [7:0]     vec_q, vec_n;
  logic [NCH-1:0] evt_all, cand;
  logic           cand_any, ack_go, sw_mode;

  assign evt_all = {src_evt, port_evt};
  assign cand    = pend_q & msk_q;
  assign sw_mode = vreg_q[0];
  assign ack_go  = irq_ack && req_q;

  pic_prio_pick #(.N(NCH), .IW(CHW)) u_pick (
    .cand(cand),
    .any (cand_any),
    .idx (pick_idx)
  );

  assign cur_ch = cand_any ? pick_idx : ch_q;

  always_comb begin
    ena_n = ena_q;
    if (we_ena_h) ena_n[NCH-1:BYTE] = reg_wdata;
    if (we_ena_l) ena_n[BYTE-1:0]   = reg_wdata;

    msk_n = msk_q;
    if (we_msk_h) msk_n[NCH-1:BYTE] = reg_wdata;
    if (we_msk_l) msk_n[BYTE-1:0]   = reg_wdata;

    pend_n = pend_q | (evt_all & ena_q);
    if (we_ena_h || we_ena_l) pend_n = pend_n & ena_n;
    if (we_pnd_h) pend_n = pend_n & {reg_wdata, {BYTE{1'b1}}};
    if (we_pnd_l) pend_n = pend_n & {{BYTE{1'b1}}, reg_wdata};
    if (ack_go)   pend_n[cur_ch] = 1'b0;

    isr_n = isr_q;
    if (we_srv_h) isr_n[NCH-1:BYTE] = reg_wdata;
    if (we_srv_l) isr_n[BYTE-1:0]   = reg_wdata;
    if (we_vec && !reg_wdata[3]) isr_n = '0;
    if (ack_go && sw_mode) isr_n[cur_ch] = 1'b1;

    vreg_n = we_vec ? reg_wdata[7:3] : vreg_q;

    if (ack_go)                                   req_n = 1'b0;
    else if (!req_q && cand_any && isr_q == '0)   req_n = 1'b1;
    else                                          req_n = req_q;

    ch_n  = cur_ch;
    vld_n = ack_go;
    vec_n = ack_go ? {vreg_q[4:1], cur_ch} : vec_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ena_q  <= '0;
      pend_q <= '0;
      msk_q  <= '0;
      isr_q  <= '0;
      vreg_q <= '0;
      req_q  <= 1'b0;
      ch_q   <= '0;
      vld_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      ena_q  <= ena_n;
      pend_q <= pend_n;
      msk_q  <= msk_n;
      isr_q  <= isr_n;
      vreg_q <= vreg_n;
      req_q  <= req_n;
      ch_q   <= ch_n;
      vld_q  <= vld_n;
      vec_q  <= vec_n;
    end
  end

  assign irq_req     = req_q;
  assign irq_vec_vld = vld_q;
  assign irq_vec     = vec_q;

  // read mux
  always_comb begin
    case (reg_addr)
      A_GPDAT: reg_rdata = port_rd;
      A_EDGE:  reg_rdata = edge_q;
      A_DIR:   reg_rdata = dir_q;
      A_ENA_H: reg_rdata = ena_q[NCH-1:BYTE];
      A_ENA_L: reg_rdata = ena_q[BYTE-1:0];
      A_PND_H: reg_rdata = pend_q[NCH-1:BYTE];
      A_PND_L: reg_rdata = pend_q[BYTE-1:0];
      A_SRV_H: reg_rdata = isr_q[NCH-1:BYTE];
      A_SRV_L: reg_rdata = isr_q[BYTE-1:0];
      A_MSK_H: reg_rdata = msk_q[NCH-1:BYTE];
      A_MSK_L: reg_rdata = msk_q[BYTE-1:0];
      A_VEC:   reg_rdata = {vreg_q, 3'b000};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/vect_irq_ctrl_chk.sv
module vect_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_ni,
  input logic        irq_req,
  input logic        irq_ack,
  input logic        irq_vec_vld,
  input logic [7:0]  irq_vec,
  input logic [15:0] pend_q,
  input logic [15:0] ena_q,
  input logic [15:0] isr_q,
  input logic [4:0]  vreg_q,
  input logic [7:0]  gpio_out,
  input logic [7:0]  gpio_oe
);
  // R2: a new request only starts from an idle in-service state
  p_no_req_in_service_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(irq_req) |-> $past(isr_q) == 16'h0000);

  // R3: a pending bit can only appear on an enabled channel
  p_pend_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q)) & ~$past(ena_q)) == 16'h0000);

  // R4: acknowledge drops the request and yields one valid vector cycle
  p_ack_handshake_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_ack && irq_req) |=> (irq_vec_vld && !irq_req));

  p_vld_single_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_vec_vld |=> !irq_vec_vld);

  p_vec_base_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_vec_vld |-> irq_vec[7:4] == $past(vreg_q[4:1]));

  // R5: software mode marks the granted channel in service
  p_sw_marks_isr_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_vec_vld && $past(vreg_q[0])) |-> isr_q[irq_vec[3:0]]);

  // R8: the latch never moves on a pin that was an input
  p_out_only_driven_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    ((gpio_out ^ $past(gpio_out)) & ~$past(gpio_oe)) == 8'h00);
endmodule

bind vect_irq_ctrl vect_irq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_ni     (rst_q_n),
  .irq_req    (irq_req),
  .irq_ack    (irq_ack),
  .irq_vec_vld(irq_vec_vld),
  .irq_vec    (irq_vec),
  .pend_q     (pend_q),
  .ena_q      (ena_q),
  .isr_q      (isr_q),
  .vreg_q     (vreg_q),
  .gpio_out   (gpio_out),
  .gpio_oe    (gpio_oe)
);

// File: tb/vect_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vect_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] src_evt, gpio_in, gpio_out, gpio_oe, irq_vec;
  logic       irq_req, irq_ack, irq_vec_vld;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  vect_irq_ctrl u_vect_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_evt(src_evt),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
    .irq_req(irq_req), .irq_ack(irq_ack), .irq_vec_vld(irq_vec_vld),
    .irq_vec(irq_vec)
  );

  localparam logic [3:0] GPD = 4'h0, EDG = 4'h1, DIR = 4'h2, ENH = 4'h3, ENL = 4'h4,
                         PNH = 4'h5, PNL = 4'h6, SVH = 4'h7, SVL = 4'h8,
                         MKH = 4'h9, MKL = 4'hA, VEC = 4'hB;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [7:0] exp);
    reg_addr = a;
    #0.5;
    check(tag, reg_rdata, exp);
  endtask

  task automatic pulse(input logic [7:0] m);
    src_evt = m;
    tick(1);
    src_evt = '0;
  endtask

  task automatic do_ack(input string tag, input logic [7:0] exp_vec);
    irq_ack = 1'b1;
    tick(1);
    irq_ack = 1'b0;
    check({tag, " vld"}, {7'd0, irq_vec_vld}, 8'h01);
    check({tag, " vec"}, irq_vec, exp_vec);
    check({tag, " req drop"}, {7'd0, irq_req}, 8'h00);
  endtask

  task automatic t_reset;
    check("R10 req", {7'd0, irq_req}, 8'h00);
    check("R10 vld", {7'd0, irq_vec_vld}, 8'h00);
    check("R10 oe", gpio_oe, 8'h00);
    check("R10 out", gpio_out, 8'h00);
    rd("R10 ena_h", ENH, 8'h00);
    rd("R10 pnd_l", PNL, 8'h00);
    rd("R10 msk_h", MKH, 8'h00);
    rd("R10 srv_l", SVL, 8'h00);
    rd("R10 edge", EDG, 8'h00);
    rd("R10 vec", VEC, 8'h00);
  endtask

  task automatic t_enable_gate;
    pulse(8'h01);
    tick(2);
    rd("R3 disabled event dropped", PNH, 8'h00);
    wr(ENH, 8'h01);
    pulse(8'h01);
    rd("R3 enabled event latched", PNH, 8'h01);
    wr(ENH, 8'h00);
    rd("R3 enable write clears pending", PNH, 8'h00);
  endtask

  task automatic t_priority;
    wr(VEC, 8'h40);
    wr(ENH, 8'h91);
    wr(MKH, 8'h91);
    pulse(8'h91);
    tick(1);
    check("R9 req after two edges", {7'd0, irq_req}, 8'h01);
    tick(8);
    check("R9 req held", {7'd0, irq_req}, 8'h01);
    do_ack("R1 R4 first ch15", 8'h4F);
    tick(2);
    do_ack("R1 R4 second ch12", 8'h4C);
    tick(2);
    do_ack("R1 R4 third ch8", 8'h48);
    tick(2);
    check("R4 no req when drained", {7'd0, irq_req}, 8'h00);
    rd("R4 pendings cleared", PNH, 8'h00);
    wr(MKH, 8'h01);
    pulse(8'h81);
    tick(2);
    do_ack("R1 masked ch15 skipped", 8'h48);
    tick(2);
    check("R1 masked never requested", {7'd0, irq_req}, 8'h00);
    rd("R1 masked stays pending", PNH, 8'h80);
    wr(PNH, 8'h00);
  endtask

  task automatic t_sw_mode;
    wr(VEC, 8'h58);
    rd("R5 vec readback", VEC, 8'h58);
    wr(ENH, 8'h11);
    wr(MKH, 8'h11);
    pulse(8'h01);
    tick(2);
    do_ack("R5 sw grant ch8", 8'h58);
    rd("R5 in-service set", SVH, 8'h01);
    pulse(8'h10);
    tick(4);
    check("R2 blocked by in-service", {7'd0, irq_req}, 8'h00);
    rd("R2 still pending", PNH, 8'h10);
    wr(SVH, 8'h00);
    tick(2);
    check("R2 released", {7'd0, irq_req}, 8'h01);
    do_ack("R5 sw grant ch12", 8'h5C);
    rd("R5 in-service ch12", SVH, 8'h10);
    wr(VEC, 8'h50);
    rd("R5 auto clears in-service", SVH, 8'h00);
    rd("R5 vec auto readback", VEC, 8'h50);
    wr(VEC, 8'hFF);
    rd("R5 low bits not stored", VEC, 8'hF8);
    wr(VEC, 8'h40);
    rd("R5 leave sw clears", SVH, 8'h00);
  endtask

  task automatic t_pend_write;
    wr(MKH, 8'h00);
    pulse(8'h11);
    rd("R6 both pending", PNH, 8'h11);
    wr(PNH, 8'h10);
    rd("R6 zero clears", PNH, 8'h10);
    wr(PNH, 8'hFF);
    rd("R6 one keeps", PNH, 8'h10);
    wr(PNH, 8'h00);
    wr(SVL, 8'hA5);
    rd("R6 in-service direct", SVL, 8'hA5);
    wr(SVL, 8'h00);
    wr(ENH, 8'h00);
  endtask

  task automatic t_gpio_edge;
    wr(ENL, 8'hFF);
    gpio_in = 8'h01;
    tick(4);
    rd("R7 rising on falling-select ignored", PNL, 8'h00);
    gpio_in = 8'h00;
    tick(4);
    rd("R7 falling edge pin0", PNL, 8'h01);
    wr(PNL, 8'h00);
    wr(EDG, 8'h02);
    gpio_in = 8'h02;
    tick(4);
    rd("R7 rising edge pin1", PNL, 8'h02);
    wr(PNL, 8'h00);
    gpio_in = 8'h00;
    tick(4);
    rd("R7 falling on rising-select ignored", PNL, 8'h00);
    wr(DIR, 8'h04);
    gpio_in = 8'h04;
    tick(4);
    gpio_in = 8'h00;
    tick(4);
    rd("R7 output pin no event", PNL, 8'h00);
    wr(MKL, 8'h01);
    gpio_in = 8'h01;
    tick(4);
    gpio_in = 8'h00;
    tick(6);
    check("R7 port channel requests", {7'd0, irq_req}, 8'h01);
    do_ack("R7 port ch0 vector", 8'h40);
    wr(MKL, 8'h00);
    wr(ENL, 8'h00);
    wr(DIR, 8'h00);
    wr(EDG, 8'h00);
  endtask

  task automatic t_gpio_data;
    wr(DIR, 8'hF0);
    wr(GPD, 8'hAA);
    check("R8 only outputs latched", gpio_out, 8'hA0);
    check("R8 direction shown", gpio_oe, 8'hF0);
    gpio_in = 8'h05;
    tick(3);
    rd("R8 merged read", GPD, 8'hA5);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    src_evt = '0; gpio_in = '0; irq_ack = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_enable_gate();
    t_priority();
    t_sw_mode();
    t_pend_write();
    t_gpio_edge();
    t_gpio_data();
    rst_n = 1'b0;
    tick(2);
    check("R10 reset clears latch", gpio_out, 8'h00);
    check("R10 reset clears dir", gpio_oe, 8'h00);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule